// File: doc/BRIEF.md
# GPIO Bank with Latched Interrupt Detection

A single bank of general-purpose pins controlled through eight word-wide registers on a simple single-cycle register bus. Each pin either drives a software-written value or is left as an input, and the current level of every pin can always be read back, whatever its direction. Pin levels pass through a two-flop synchronizer before they are used.

Each pin has its own event detector. Software picks edge or level detection, and a polarity, per pin. Detected events set a sticky status bit, and software clears that bit by writing a one to a clear register. Level events are latched the same way as edges, so a level source that is still active sets its status bit again at once after a clear. One interrupt line, registered, reports whether any pin with its enable bit set has a pending status bit. The bank is built for up to one bus word of pins, and it may use fewer. Bits above the used pin count read as zero.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output value, output enable, edge-select, polarity and interrupt-enable registers read zero and `irq` is low. Under these defaults (level, active low) a pin held low becomes pending in status.
- R2: Register word addresses: 0 output value, 1 output enable, 2 pin input, 3 edge select, 4 polarity, 5 interrupt enable, 6 clear, 7 status. Bit n of every register maps to pin n. Writes to 0, 1, 3, 4 and 5 are read back, and `pin_out`/`pin_oe` follow registers 0/1. A 1 in `pin_oe` means the pin drives `pin_out`.
- R3: Bits at and above NPIN read as zero in every register, even after all-ones writes.
- R4: Register 2 returns the synchronized level of every pin, including pins driven as outputs. Read data appears one cycle after the address.
- R5: With edge select 1 and polarity 1, a low-to-high pin change sets that pin's status bit, and a high-to-low change does not.
- R6: With edge select 1 and polarity 0, a high-to-low change sets status, and a low-to-high change does not.
- R7: With edge select 0, a pin whose level equals its polarity bit sets status. The bit stays set after the level goes away, until it is cleared.
- R8: Writing 1 to a bit of register 6 clears that status bit. Writing 0 leaves it unchanged. Register 6 reads as zero.
- R9: An event in the same cycle as a clear of that bit wins, so the bit stays set.
- R10: Status latches events whatever the enable setting. `irq` is high exactly when (status AND enable) was nonzero in the previous cycle.
- R11: Changing a polarity bit while the pin is steady in edge mode creates no event.
- R12: Writes to the input (2) and status (7) addresses have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data for the address of the previous cycle |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_out | output | NPIN | Output value to drive on the pins |
| pin_oe | output | NPIN | Per-pin output enable, 1 drives |
| irq | output | 1 | Registered summary interrupt |

## Verification
The bench drives several corner cases. A polarity flip on a steady pin in edge mode would show a false event in a design that compared the level against polarity instead of against the previous sample. A clear written while a level source is still active must leave the bit set: a design where the clear wins would drop that event. Falling edges under rising polarity must not set status, and the status of a level source must outlive its level. A summary line that ignored the enable mask, or that dropped status while enables were off, would be caught by checks that compare `irq` with a model of status AND enable. Random pin patterns in rising-edge mode are compared with a model that accumulates new-high bits.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef enum logic [2:0] {
    RA_OUT  = 3'd0,
    RA_OE   = 3'd1,
    RA_IN   = 3'd2,
    RA_EDGE = 3'd3,
    RA_POL  = 3'd4,
    RA_IEN  = 3'd5,
    RA_CLR  = 3'd6,
    RA_STAT = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] oe_q,
  output logic [DW-1:0] edge_q,
  output logic [DW-1:0] pol_q,
  output logic [DW-1:0] ien_q,
  output logic [DW-1:0] clr_vec
);
  localparam logic [DW-1:0] USED = DW'((64'd1 << NPIN) - 64'd1);

  logic [DW-1:0] wmask;
  assign wmask = wdata & USED;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      oe_q   <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (we) begin
      case (reg_addr_e'(addr))
        RA_OUT:  out_q  <= wmask;
        RA_OE:   oe_q   <= wmask;
        RA_EDGE: edge_q <= wmask;
        RA_POL:  pol_q  <= wmask;
        RA_IEN:  ien_q  <= wmask;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_vec = '0;
    if (we && reg_addr_e'(addr) == RA_CLR) clr_vec = wmask;
  end
endmodule

// File: rtl/gpb_detect.sv
module gpb_detect #(
  parameter int NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] edge_sel,
  input  logic [NPIN-1:0] pol,
  input  logic [NPIN-1:0] clr,
  output logic [NPIN-1:0] status
);
  logic [NPIN-1:0] prev;
  logic [NPIN-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl;
  end

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic rise, fall, lvl_match;
      assign rise      = lvl[i] & ~prev[i];
      assign fall      = ~lvl[i] & prev[i];
      assign lvl_match = (lvl[i] == pol[i]);
      assign hit[i]    = edge_sel[i] ? (pol[i] ? rise : fall) : lvl_match;

      always_ff @(posedge clk) begin
        if (rst)         status[i] <= 1'b0;
        else if (hit[i]) status[i] <= 1'b1;
        else if (clr[i]) status[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpb_pkg::*;
#(
  parameter int NPIN        = 16,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  logic [DW-1:0]   out_q, oe_q, edge_q, pol_q, ien_q, clr_vec;
  logic [NPIN-1:0] lvl_s;
  logic [NPIN-1:0] status_q;
  logic [DW-1:0]   lvl_w, stat_w;

  gpb_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl_s)
  );

  gpb_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .out_q(out_q), .oe_q(oe_q), .edge_q(edge_q), .pol_q(pol_q),
    .ien_q(ien_q), .clr_vec(clr_vec)
  );

  gpb_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst(rst), .lvl(lvl_s),
    .edge_sel(edge_q[NPIN-1:0]), .pol(pol_q[NPIN-1:0]),
    .clr(clr_vec[NPIN-1:0]), .status(status_q)
  );

  always_comb begin
    lvl_w  = '0;
    stat_w = '0;
    lvl_w[NPIN-1:0]  = lvl_s;
    stat_w[NPIN-1:0] = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(stat_w & ien_q);
      case (reg_addr_e'(bus_addr))
        RA_OUT:  bus_rdata <= out_q;
        RA_OE:   bus_rdata <= oe_q;
        RA_IN:   bus_rdata <= lvl_w;
        RA_EDGE: bus_rdata <= edge_q;
        RA_POL:  bus_rdata <= pol_q;
        RA_IEN:  bus_rdata <= ien_q;
        RA_STAT: bus_rdata <= stat_w;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign pin_out = out_q[NPIN-1:0];
  assign pin_oe  = oe_q[NPIN-1:0];
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
  parameter int NPIN = 16,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] status_q,
  input logic [DW-1:0]   ien_q,
  input logic [DW-1:0]   clr_vec,
  input logic            irq
);
  localparam logic [DW-1:0] USED = DW'((64'd1 << NPIN) - 64'd1);

  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 3'd1) |=> (pin_oe == $past(bus_wdata[NPIN-1:0]))); // R2

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~USED) == '0); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(clr_vec) == '0) |-> ((status_q & $past(status_q)) == $past(status_q))); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> (($past(status_q) & $past(ien_q[NPIN-1:0])) != '0)); // R10

  AST_IRQ_NOT_MISSED: assert property (@(posedge clk) disable iff (rst)
    (((status_q & ien_q[NPIN-1:0]) != '0) && !$past(rst)) |=> irq); // R10
endmodule

bind gpio_irq_bank gpb_checker #(.NPIN(NPIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
  .status_q(status_q), .ien_q(ien_q), .clr_vec(clr_vec), .irq(irq)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int NPIN = 16;
  localparam int DW   = 32;
  localparam logic [DW-1:0] USED = 32'h0000_FFFF;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_we = 1'b0;
  logic [2:0]      bus_addr = 3'd0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe;
  logic            irq;

  int n_run = 0;
  int n_fail = 0;

  gpio_irq_bank #(.NPIN(NPIN), .DW(DW)) i_gpio_irq_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] ext(input logic [NPIN-1:0] v);
    return {{(DW-NPIN){1'b0}}, v};
  endfunction

  function automatic logic [NPIN-1:0] rises(input logic [NPIN-1:0] o, input logic [NPIN-1:0] n);
    return n & ~o;
  endfunction

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic [NPIN-1:0] old_p, new_p, exp_st, ien, m;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 irq", ext(irq), 0);
    rd(3'd0, v); chk("R1 out", v, 0);
    rd(3'd1, v); chk("R1 oe", v, 0);
    rd(3'd3, v); chk("R1 edge", v, 0);
    rd(3'd4, v); chk("R1 pol", v, 0);
    rd(3'd5, v); chk("R1 ien", v, 0);
    settle();
    rd(3'd7, v); chk("R1 level-low default pending", v, USED);
    chk("R1 irq still low", ext(irq), 0);

    // R2 / R3 readback, unused bits
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R3 out mask", v, USED);
    chk("R2 pin_out", ext(pin_out), USED);
    wr(3'd1, 32'hA5A5_0F0F); rd(3'd1, v); chk("R3 oe mask", v, 32'h0000_0F0F);
    chk("R2 pin_oe", ext(pin_oe), 32'h0000_0F0F);
    wr(3'd0, 32'h0000_1234); rd(3'd0, v); chk("R2 out value", v, 32'h1234);

    // R4 input read incl. output pins
    pin_in = 16'h0F3C; settle();
    rd(3'd2, v); chk("R4 input read", v, 32'h0F3C);

    // R5 rising edge
    pin_in = '0;
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF); settle();
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd7, v); chk("R5 cleared", v, 0);
    pin_in = 16'h0005; settle();
    rd(3'd7, v); chk("R5 rise sets", v, 32'h0005);
    pin_in = 16'h0000; settle();
    rd(3'd7, v); chk("R5 fall ignored", v, 32'h0005);

    // R8 write-one-to-clear
    wr(3'd6, 32'h0000_0000); rd(3'd7, v); chk("R8 zero no effect", v, 32'h0005);
    wr(3'd6, 32'h0000_0001); rd(3'd7, v); chk("R8 one clears", v, 32'h0004);
    rd(3'd6, v); chk("R8 clear reads zero", v, 0);

    // R12 writes to input/status ignored
    wr(3'd7, 32'h0000_FFFF); rd(3'd7, v); chk("R12 status write", v, 32'h0004);
    wr(3'd2, 32'h0000_FFFF); rd(3'd2, v); chk("R12 input write", v, 0);

    // R6 falling edge
    wr(3'd4, 32'h0); wr(3'd6, 32'hFFFF_FFFF);
    pin_in = 16'h00FF; settle();
    rd(3'd7, v); chk("R6 rise ignored", v, 0);
    pin_in = 16'h0000; settle();
    rd(3'd7, v); chk("R6 fall sets", v, 32'h00FF);

    // R11 polarity flip on steady pins
    pin_in = 16'hFFFF; settle();
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF); settle();
    rd(3'd7, v); chk("R11 pol flip high", v, 0);
    wr(3'd4, 32'h0); settle();
    rd(3'd7, v); chk("R11 pol flip low", v, 0);

    // R7 level high latched
    pin_in = 16'h0000; wr(3'd4, 32'hFFFF_FFFF); settle();
    wr(3'd3, 32'h0); wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd7, v); chk("R7 idle", v, 0);
    pin_in = 16'h0100; settle();
    rd(3'd7, v); chk("R7 level sets", v, 32'h0100);

    // R9 event and clear in the same cycle
    wr(3'd6, 32'h0000_0100); rd(3'd7, v); chk("R9 set wins", v, 32'h0100);

    // R10 enable gating
    chk("R10 disabled irq low", ext(irq), 0);
    wr(3'd5, 32'h0000_0200); settle(); chk("R10 other enable", ext(irq), 0);
    wr(3'd5, 32'h0000_0100); settle(); chk("R10 enabled irq", ext(irq), 1);
    pin_in = 16'h0000; settle();
    rd(3'd7, v); chk("R7 latched after level gone", v, 32'h0100);
    wr(3'd6, 32'h0000_0100); settle();
    rd(3'd7, v); chk("R8 level cleared", v, 0);
    chk("R10 irq drops", ext(irq), 0);

    // random: rising-edge mode, model accumulates new-high bits
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    settle(); wr(3'd6, 32'hFFFF_FFFF);
    old_p = '0; exp_st = '0; ien = '0;
    for (int k = 0; k < 40; k++) begin
      new_p = NPIN'($urandom);
      pin_in = new_p; settle();
      exp_st |= rises(old_p, new_p);
      old_p = new_p;
      rd(3'd7, v); chk("R5 random status", v, ext(exp_st));
      rd(3'd2, v); chk("R4 random input", v, ext(new_p));
      if ($urandom_range(0, 2) == 0) begin
        m = NPIN'($urandom);
        wr(3'd6, ext(m));
        exp_st &= ~m;
      end
      ien = NPIN'($urandom) & NPIN'($urandom);
      wr(3'd5, ext(ien)); settle();
      chk("R10 random irq", ext(irq), ext({15'd0, |(exp_st & ien)}));
      v = 32'($urandom);
      wr(3'd0, v); rd(3'd0, v); chk("R2 random out", v, ext(pin_out));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule